// File: doc/BRIEF.md
# Predecoded Multiport Register Array

This block is a 64-word by 24-bit register array with two read ports and one write port per clock phase. Each port presents a strobe and a 6-bit word address. The block captures them in port latches on a clock edge. It then predecodes each latched address into twelve strobe-gated select lines, arranged as three groups of four one-hot lines. Those lines are combined into one of 64 word selects.

Storage is banked into eight subarrays of 16 words by 12 bits. Four row banks each hold a low column half and a high column half of every word. Subarrays in the same half of the address space are merged locally. The top address bit then picks between the two half-array results, and the result is registered as read data.

A mode input enables double pumping. In that mode a second set of port slots is serviced after the first in the same clock, so the array performs four reads and two writes per cycle. Ordering between the two phases is fixed. With the mode off, the second-phase slots are ignored. The block models the cycle-level logical effect of a precharged domino array, not its circuit behaviour.

Top module: `predec_regarray`

## Requirements
- R1: A synchronous active-low reset clears every read output and every stored word to zero.
- R2: A read strobed at clock edge k has its data on the read output after edge k+1, and the data stays there until the slot's next strobed read completes.
- R3: A write strobed at edge k stores all 24 bits of its data at the binary word index given by its address. A read strobed at edge k+1 or later returns that data, with bits 11:0 and 23:12 both correct.
- R4: Each strobed access selects exactly one word. The address splits into three 2-bit groups (bits 1:0, 3:2, 5:4), each decoded to a one-hot 1-of-4 line set. Every one of the 64 addresses reaches a distinct word.
- R5: A read slot whose strobe is low keeps its previous output value.
- R6: A write slot whose strobe is low leaves every stored word unchanged.
- R7: A read and a write to the same address strobed at the same edge in the same phase return the old data. The new data is visible to later reads.
- R8: With double pumping on (dbl_mode = 1), a second-phase read of an address written in the first phase of the same cycle returns the new data.
- R9: With double pumping on, a first-phase read does not see a second-phase write from the same cycle. When both phases write one address, the second-phase data remains.
- R10: With double pumping off (dbl_mode = 0) at the strobe edge, the second-phase slots (read slots 2 and 3, write slot 1) are ignored. Their outputs hold and no storage changes.
- R11: The read slots are independent. Two slots in one cycle may read different or identical addresses and each returns its own word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbl_mode | input | 1 | Enables the second-phase slots (double pumping) |
| rd_stb | input | 4 | Read strobes; slot s = phase*2 + port |
| rd_addr | input | 24 | Read addresses, 6 bits per slot, slot s at bits 6s+5:6s |
| rd_data | output | 96 | Read data, 24 bits per slot, slot s at bits 24s+23:24s |
| wr_stb | input | 2 | Write strobes; bit 0 first phase, bit 1 second phase |
| wr_addr | input | 12 | Write addresses, 6 bits per phase |
| wr_data | input | 48 | Write data, 24 bits per phase |

## Verification
Several properties are checked on every cycle:
- each predecode group is one-hot under its strobe and all-zero without it;
- at most one word line and at most one bank fire per slot;
- an unstrobed or disabled read slot holds its output;
- a stored row takes the data of the later write phase that selected it.

Three behaviours are only visible across whole sequences of operations. These are data returned after a full address sweep, the read-during-write and cross-phase ordering, and the effect of the mode bit. The bench shows them with a behavioural model that it compares on every clock, and with directed scenarios that carry known values.

// File: rtl/regarr_pkg.sv
// Shared sizing for the predecoded register array.
// Assumes ADDR_W is a multiple of PDEC_GRP_W.
package regarr_pkg;
    localparam int PDEC_GRP_W = 2;                 // address bits per predecode group
    localparam int PDEC_NL    = 1 << PDEC_GRP_W;   // one-hot lines per group
    localparam int NPHASE     = 2;                 // clock phases when double pumped
    localparam int NCOLH      = 2;                 // column halves per word
    localparam int NHALF      = 2;                 // address halves merged at the output
endpackage

// File: rtl/regarr_predecode.sv
// Strobe-gated address predecoder.
// Splits the address into groups of PDEC_GRP_W bits and turns each group
// into a one-hot line set. All lines are zero while the strobe is low.
// Assumes ADDR_W is a multiple of PDEC_GRP_W.
module regarr_predecode
    import regarr_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int NGRP  = ADDR_W / PDEC_GRP_W,
    localparam int LINES = NGRP * PDEC_NL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [ADDR_W-1:0] addr,
    output logic [LINES-1:0]  lines
);
    genvar g, k;
    generate
        for (g = 0; g < NGRP; g++) begin : g_grp
            for (k = 0; k < PDEC_NL; k++) begin : g_line
                // One select line: strobe AND group value equals k
                assign lines[g*PDEC_NL + k] =
                    stb && (addr[g*PDEC_GRP_W +: PDEC_GRP_W] == PDEC_GRP_W'(k));
            end

            // R4
            pdec_grp_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                stb |-> $countones(lines[g*PDEC_NL +: PDEC_NL]) == 1);
            // R4
            pdec_grp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !stb |-> lines[g*PDEC_NL +: PDEC_NL] == '0);
        end
    endgenerate
endmodule

// File: rtl/regarr_wordsel.sv
// Word-line decoder.
// Combines one line from each predecode group into a word select.
// Raises the precharge enable whenever the port is strobed.
// Assumes its input comes from regarr_predecode with the same ADDR_W.
module regarr_wordsel
    import regarr_pkg::*;
#(
    parameter int ADDR_W = 6,
    localparam int NGRP  = ADDR_W / PDEC_GRP_W,
    localparam int LINES = NGRP * PDEC_NL,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    output logic [DEPTH-1:0] wl,
    output logic             pre_en
);
    // Word select: AND of the matching line of every group
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            logic hit;
            hit = 1'b1;
            for (int g = 0; g < NGRP; g++) begin
                hit = hit & lines[g*PDEC_NL + ((i >> (g*PDEC_GRP_W)) % PDEC_NL)];
            end
            wl[i] = hit;
        end
    end

    // Precharge enable: any line of the first group is active
    assign pre_en = |lines[PDEC_NL-1:0];

    // R4
    wl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wl));
    // R4
    wl_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pre_en |-> $countones(wl) == 1);
endmodule

// File: rtl/regarr_subarray.sv
// One banked subarray of ROWS words by COLS bits with phase-ordered ports.
// First-phase reads see the stored rows. The first-phase write then applies.
// Second-phase reads see that updated view. The second-phase write lands last.
// All selects are assumed one-hot or zero (from regarr_wordsel).
module regarr_subarray
    import regarr_pkg::*;
#(
    parameter int ROWS = 16,
    parameter int COLS = 12,
    parameter int NRD  = 2,
    localparam int NSLOT = NPHASE * NRD
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [NSLOT-1:0][ROWS-1:0]       rsel,
    input  logic [NPHASE-1:0][ROWS-1:0]      wsel,
    input  logic [NPHASE-1:0][COLS-1:0]      wd,
    output logic [NSLOT-1:0][COLS-1:0]       rd_o
);
    logic [COLS-1:0] mem     [ROWS];
    logic [COLS-1:0] row_mid [ROWS];

    // Row contents as seen after the first-phase write
    always_comb begin
        for (int r = 0; r < ROWS; r++) begin
            row_mid[r] = wsel[0][r] ? wd[0] : mem[r];
        end
    end

    // Bitline evaluation: OR of the selected rows per read slot
    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            logic [COLS-1:0] acc;
            acc = '0;
            for (int r = 0; r < ROWS; r++) begin
                if (rsel[s][r]) acc = acc | ((s < NRD) ? mem[r] : row_mid[r]);
            end
            rd_o[s] = acc;
        end
    end

    // Storage update: the second phase overrides the first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < ROWS; r++) mem[r] <= '0;
        end else begin
            for (int r = 0; r < ROWS; r++) begin
                if (wsel[1][r])      mem[r] <= wd[1];
                else if (wsel[0][r]) mem[r] <= wd[0];
            end
        end
    end

    genvar r;
    generate
        for (r = 0; r < ROWS; r++) begin : g_rowchk
            // R3
            row_wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wsel[0][r] && !wsel[1][r] |=> mem[r] == $past(wd[0]));
            // R9
            row_wr_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wsel[1][r] |=> mem[r] == $past(wd[1]));
            // R6
            row_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !wsel[0][r] && !wsel[1][r] |=> $stable(mem[r]));
        end
    endgenerate
endmodule

// File: rtl/predec_regarray.sv
// Predecoded 2R1W register array with optional double pumping (4R2W).
// Port strobes and addresses are captured in latches at a clock edge.
// In the following cycle they are predecoded, decoded to word lines, and
// applied to eight banked subarrays. Read data is merged per address half,
// selected by the top address bit, and registered at the next edge.
// Assumes DATA_W is even and DEPTH is a multiple of SUB_ROWS*NHALF.
module predec_regarray
    import regarr_pkg::*;
#(
    parameter int ADDR_W   = 6,
    parameter int DATA_W   = 24,
    parameter int SUB_ROWS = 16,
    parameter int NRD      = 2,
    localparam int NSLOT   = NPHASE * NRD,
    localparam int NGRP    = ADDR_W / PDEC_GRP_W,
    localparam int LINES   = NGRP * PDEC_NL
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       dbl_mode,
    input  logic [NSLOT-1:0]           rd_stb,
    input  logic [NSLOT*ADDR_W-1:0]    rd_addr,
    output logic [NSLOT*DATA_W-1:0]    rd_data,
    input  logic [NPHASE-1:0]          wr_stb,
    input  logic [NPHASE*ADDR_W-1:0]   wr_addr,
    input  logic [NPHASE*DATA_W-1:0]   wr_data
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int SUB_COLS  = DATA_W / NCOLH;
    localparam int NBANK     = DEPTH / SUB_ROWS;
    localparam int BPH       = NBANK / NHALF;

    // ---- port latches ----
    logic [NSLOT-1:0]                rstb_q;
    logic [NSLOT-1:0][ADDR_W-1:0]    raddr_q;
    logic [NPHASE-1:0]               wstb_q;
    logic [NPHASE-1:0][ADDR_W-1:0]   waddr_q;
    logic [NPHASE-1:0][DATA_W-1:0]   wdata_q;

    // Capture port controls; second-phase strobes only count in double mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rstb_q  <= '0;
            raddr_q <= '0;
            wstb_q  <= '0;
            waddr_q <= '0;
            wdata_q <= '0;
        end else begin
            for (int s = 0; s < NSLOT; s++) begin
                rstb_q[s]  <= rd_stb[s] && ((s < NRD) || dbl_mode);
                raddr_q[s] <= rd_addr[s*ADDR_W +: ADDR_W];
            end
            for (int p = 0; p < NPHASE; p++) begin
                wstb_q[p]  <= wr_stb[p] && ((p == 0) || dbl_mode);
                waddr_q[p] <= wr_addr[p*ADDR_W +: ADDR_W];
                wdata_q[p] <= wr_data[p*DATA_W +: DATA_W];
            end
        end
    end

    // ---- predecode and word lines ----
    logic [NSLOT-1:0][LINES-1:0]   rlines;
    logic [NSLOT-1:0][DEPTH-1:0]   rwl;
    logic [NSLOT-1:0]              rpre;
    logic [NPHASE-1:0][LINES-1:0]  wlines;
    logic [NPHASE-1:0][DEPTH-1:0]  wwl;
    logic [NPHASE-1:0]             wpre;

    genvar s, p, b, c;
    generate
        for (s = 0; s < NSLOT; s++) begin : g_rdec
            regarr_predecode #(.ADDR_W(ADDR_W)) u_pdec (
                .clk(clk), .rst_n(rst_n), .stb(rstb_q[s]),
                .addr(raddr_q[s]), .lines(rlines[s]));
            regarr_wordsel #(.ADDR_W(ADDR_W)) u_wsel (
                .clk(clk), .rst_n(rst_n), .lines(rlines[s]),
                .wl(rwl[s]), .pre_en(rpre[s]));
        end
        for (p = 0; p < NPHASE; p++) begin : g_wdec
            regarr_predecode #(.ADDR_W(ADDR_W)) u_pdec (
                .clk(clk), .rst_n(rst_n), .stb(wstb_q[p]),
                .addr(waddr_q[p]), .lines(wlines[p]));
            regarr_wordsel #(.ADDR_W(ADDR_W)) u_wsel (
                .clk(clk), .rst_n(rst_n), .lines(wlines[p]),
                .wl(wwl[p]), .pre_en(wpre[p]));
        end
    endgenerate

    // ---- banked subarrays ----
    logic [NSLOT-1:0][SUB_COLS-1:0] sub_rd [NBANK][NCOLH];

    generate
        for (b = 0; b < NBANK; b++) begin : g_bank
            logic [NSLOT-1:0][SUB_ROWS-1:0]  bk_rsel;
            logic [NPHASE-1:0][SUB_ROWS-1:0] bk_wsel;

            // Slice this bank's rows out of each port's word lines
            always_comb begin
                for (int i = 0; i < NSLOT; i++)  bk_rsel[i] = rwl[i][b*SUB_ROWS +: SUB_ROWS];
                for (int j = 0; j < NPHASE; j++) bk_wsel[j] = wwl[j][b*SUB_ROWS +: SUB_ROWS];
            end

            for (c = 0; c < NCOLH; c++) begin : g_col
                logic [NPHASE-1:0][SUB_COLS-1:0] col_wd;

                // Route this column half of each write word
                always_comb begin
                    for (int j = 0; j < NPHASE; j++) col_wd[j] = wdata_q[j][c*SUB_COLS +: SUB_COLS];
                end

                regarr_subarray #(.ROWS(SUB_ROWS), .COLS(SUB_COLS), .NRD(NRD)) u_sub (
                    .clk(clk), .rst_n(rst_n), .rsel(bk_rsel), .wsel(bk_wsel),
                    .wd(col_wd), .rd_o(sub_rd[b][c]));
            end
        end
    endgenerate

    // ---- local merge and final half select ----
    logic [NSLOT-1:0][NHALF-1:0][DATA_W-1:0] loc;
    logic [NSLOT-1:0][DATA_W-1:0]            merged;

    // Merge neighbouring banks per half, then pick the half by top address bit
    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            for (int h = 0; h < NHALF; h++) begin
                loc[i][h] = '0;
                for (int k = 0; k < BPH; k++) begin
                    for (int cc = 0; cc < NCOLH; cc++) begin
                        loc[i][h][cc*SUB_COLS +: SUB_COLS] = loc[i][h][cc*SUB_COLS +: SUB_COLS]
                                                           | sub_rd[h*BPH + k][cc][i];
                    end
                end
            end
            merged[i] = loc[i][raddr_q[i][ADDR_W-1]];
        end
    end

    // ---- output registers ----
    logic [NSLOT-1:0][DATA_W-1:0] rd_q;

    // Load a slot's output only when its port was precharged this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else begin
            for (int i = 0; i < NSLOT; i++) begin
                if (rpre[i]) rd_q[i] <= merged[i];
            end
        end
    end

    assign rd_data = rd_q;

    // ---- port-level checks ----
    generate
        for (s = 0; s < NSLOT; s++) begin : g_chk
            localparam bit SECOND = (s >= NRD);
            logic [NBANK-1:0] bank_hit;

            // Which banks this slot's word line lands in
            always_comb begin
                for (int k = 0; k < NBANK; k++) bank_hit[k] = |rwl[s][k*SUB_ROWS +: SUB_ROWS];
            end

            // R4
            bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $onehot0(bank_hit));
            // R5
            rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !rd_stb[s] |=> ##1 $stable(rd_data[s*DATA_W +: DATA_W]));
            // R10
            if (SECOND) begin : g_single
                single_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    !dbl_mode |=> ##1 $stable(rd_data[s*DATA_W +: DATA_W]));
            end
        end
        for (p = 0; p < NPHASE; p++) begin : g_wchk
            // R6
            wr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !wr_stb[p] |=> !wpre[p]);
        end
    endgenerate
endmodule

// File: tb/predec_regarray_tb.sv
// Bench for predec_regarray: behavioural reference compared every clock,
// plus directed scenarios with hand-known values.
module predec_regarray_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbl_mode = 1'b0;
    logic [3:0]  rd_stb = '0;
    logic [23:0] rd_addr = '0;
    logic [95:0] rd_data;
    logic [1:0]  wr_stb = '0;
    logic [11:0] wr_addr = '0;
    logic [47:0] wr_data = '0;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    predec_regarray dut_i (
        .clk(clk), .rst_n(rst_n), .dbl_mode(dbl_mode),
        .rd_stb(rd_stb), .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

    function automatic logic [23:0] pat(int a);
        logic [5:0] x;
        x = 6'(a);
        return {x, ~x, x ^ 6'h15, x ^ 6'h2A};
    endfunction

    function automatic logic [23:0] slot(int s);
        return rd_data[s*24 +: 24];
    endfunction

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // ---- reference model ----
    logic [23:0] m [64];
    logic [23:0] exp_rd [4];
    logic        p_rs [4];
    int          p_ra [4];
    logic        p_ws [2];
    int          p_wa [2];
    logic [23:0] p_wd [2];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 64; i++) m[i] = '0;
            for (int s = 0; s < 4; s++) begin exp_rd[s] = '0; p_rs[s] = 0; p_ra[s] = 0; end
            for (int w = 0; w < 2; w++) begin p_ws[w] = 0; p_wa[w] = 0; p_wd[w] = '0; end
        end else begin
            for (int s = 0; s < 2; s++) if (p_rs[s]) exp_rd[s] = m[p_ra[s]];
            if (p_ws[0]) m[p_wa[0]] = p_wd[0];
            for (int s = 2; s < 4; s++) if (p_rs[s]) exp_rd[s] = m[p_ra[s]];
            if (p_ws[1]) m[p_wa[1]] = p_wd[1];
            for (int s = 0; s < 4; s++) begin
                p_rs[s] = rd_stb[s] && (s < 2 || dbl_mode);
                p_ra[s] = int'(rd_addr[s*6 +: 6]);
            end
            for (int w = 0; w < 2; w++) begin
                p_ws[w] = wr_stb[w] && (w == 0 || dbl_mode);
                p_wa[w] = int'(wr_addr[w*6 +: 6]);
                p_wd[w] = wr_data[w*24 +: 24];
            end
        end
    end

    // Every-clock comparison against the model
    always @(negedge clk) begin
        for (int s = 0; s < 4; s++) chk(cur_req, slot(s), exp_rd[s]);
    end

    // ---- stimulus helpers ----
    task automatic set_rd(int s, int a);
        rd_stb[s] = 1'b1;
        rd_addr[s*6 +: 6] = 6'(a);
    endtask

    task automatic set_wr(int p, int a, logic [23:0] d);
        wr_stb[p] = 1'b1;
        wr_addr[p*6 +: 6] = 6'(a);
        wr_data[p*24 +: 24] = d;
    endtask

    // Hold the driven inputs for one edge, then clear the strobes
    task automatic step();
        @(negedge clk);
        rd_stb = '0;
        wr_stb = '0;
    endtask

    // Wait until results of the last step are on the outputs
    task automatic settle();
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic [23:0] held;

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        for (int s = 0; s < 4; s++) chk("R1", slot(s), 24'h0);
        rst_n = 1'b1;
        set_rd(0, 9); step(); settle();
        chk("R1", slot(0), 24'h0);

        // R3: fill all words through the first write phase
        cur_req = "R3";
        for (int a = 0; a < 64; a++) begin set_wr(0, a, pat(a)); step(); end

        // R4 / R11: sweep with two ports in opposite order
        cur_req = "R4";
        for (int a = 0; a < 64; a++) begin set_rd(0, a); set_rd(1, 63 - a); step(); end
        settle();
        set_rd(0, 37); set_rd(1, 37); step(); settle();
        chk("R11", slot(0), pat(37));
        chk("R11", slot(1), pat(37));
        chk("R3", slot(0), pat(37));
        chk("R3", slot(0) & 24'h000FFF, pat(37) & 24'h000FFF);

        // R2: latency, one edge to latch and one edge to output
        cur_req = "R2";
        set_rd(0, 12); step();
        chk("R2", slot(0), pat(37));
        settle();
        chk("R2", slot(0), pat(12));

        // R5: no strobe, output holds
        cur_req = "R5";
        held = slot(0);
        rd_addr[5:0] = 6'd50; step(); settle();
        chk("R5", slot(0), held);

        // R6: unstrobed write changes nothing
        cur_req = "R6";
        wr_addr[5:0] = 6'd10; wr_data[23:0] = 24'hDEAD01; step();
        set_rd(0, 10); step(); settle();
        chk("R6", slot(0), pat(10));

        // R7: same-edge read and write return old data
        cur_req = "R7";
        set_wr(0, 20, 24'hABCDEF); set_rd(0, 20); step(); settle();
        chk("R7", slot(0), pat(20));
        set_rd(0, 20); step(); settle();
        chk("R7", slot(0), 24'hABCDEF);

        // R8: second-phase read sees first-phase write
        cur_req = "R8";
        dbl_mode = 1'b1;
        set_wr(0, 30, 24'h123456); set_rd(0, 30); set_rd(2, 30); set_rd(3, 63); step(); settle();
        chk("R8", slot(0), pat(30));
        chk("R8", slot(2), 24'h123456);
        chk("R11", slot(3), pat(63));

        // R9: first-phase read misses second-phase write; second phase wins
        cur_req = "R9";
        set_wr(0, 31, 24'h0F0F0F); set_wr(1, 31, 24'hF0F0F0);
        set_rd(1, 31); set_rd(2, 31); step(); settle();
        chk("R9", slot(1), pat(31));
        chk("R9", slot(2), 24'h0F0F0F);
        set_rd(0, 31); step(); settle();
        chk("R9", slot(0), 24'hF0F0F0);

        // R10: single mode ignores second-phase slots
        cur_req = "R10";
        dbl_mode = 1'b0;
        held = slot(2);
        set_rd(2, 0); set_wr(1, 0, 24'h777777); step(); settle();
        chk("R10", slot(2), held);
        set_rd(0, 0); step(); settle();
        chk("R10", slot(0), pat(0));

        // Mixed traffic in double mode, checked by the model
        cur_req = "R8";
        dbl_mode = 1'b1;
        for (int i = 0; i < 40; i++) begin
            set_wr(0, (i * 7) % 64, pat(i + 100));
            set_wr(1, (i * 5) % 64, pat(i + 200));
            set_rd(0, (i * 3) % 64); set_rd(1, (i * 7) % 64);
            set_rd(2, (i * 5) % 64); set_rd(3, (i * 11) % 64);
            step();
        end
        settle(); settle();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule